// File: doc/BRIEF.md
# Table-Driven Binary Keying Modulator

This block serializes a parallel data word and turns each bit into a stretch of digital carrier samples, drawn from one of two fixed sample tables. A start pulse captures the word. The word then leaves most significant bit first. While a bit is current, its value picks the table, and a table address walks through every entry. Each entry stays on the output for a fixed number of clocks. The result is a 32-bit signed sample stream that is meant to feed a converter or a later digital stage.

The same datapath becomes a phase-shift keyer or a frequency-shift keyer, and only the table contents differ. In phase mode the two tables carry one carrier cycle and its inverse. In frequency mode they carry carriers whose frequencies are in a 20:1 ratio. The mode is picked at elaboration, and the pacing is the same in both: 40 entries per bit, with each entry held for 2 clocks. That gives 80 clocks per bit, or 1.6 µs per bit at 50 MHz.

Top module: `key_table_mod`

## Requirements
- R1: While reset is high and after it is released, `busy`, `sampleValid`, `curBit` and `sampleOut` are all 0. Reset is synchronous.
- R2: A `start` pulse seen at a clock edge while `busy` is low captures `dataIn`. `busy` is then high for exactly 14*40*2 = 1120 cycles, beginning with the cycle that follows that edge.
- R3: `sampleValid` goes high one cycle after `busy` goes high and stays high for 1120 cycles. Each table entry is presented for 2 consecutive cycles.
- R4: Bits leave MSB first. For bit number b (0 to 13), over its 80 valid cycles, `curBit` equals `dataIn[13-b]` of the captured word.
- R5: A current bit of 1 selects the first table and a bit of 0 selects the second. Every bit begins at entry 0 and steps through entries 0 to 39 in order.
- R6: Let S(d) be the integer sine approximation with amplitude A = 2^30. Fold d into 0..359. Let x be d or d-180, and p = x*(180-x). The magnitude is A*4*p/(40500-p), using integer division, and the sign is negative when d is 180 or more. In phase mode (the default), entry k of the first table is S(9k) and entry k of the second table is -S(9k).
- R7: In frequency mode, entry k of the first table is S(20*9k + 90), a cosine at 20 cycles per bit, so it alternates +A and -A. Entry k of the second table is S(9k), which is one cycle per bit.
- R8: A `start` pulse while `busy` is high is ignored. The word in flight keeps its samples, bits and length unchanged.
- R9: After the last sample, `sampleValid` is low and `sampleOut` is 0 until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that captures `dataIn` when idle |
| dataIn | input | 14 | Word to transmit, MSB first |
| sampleOut | output | 32 | Signed carrier sample, 0 when idle |
| sampleValid | output | 1 | High while `sampleOut` carries a waveform sample |
| curBit | output | 1 | Bit that the present sample belongs to |
| busy | output | 1 | High while a word is being sent |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a transmission. It can hit at any of the 1120 cycles, including a bit boundary or the last hold cycle, and it must leave the sample stream untouched. Each random word therefore gets an intruding start with a different word, at a cycle drawn from `$urandom`, and every sample of the run is compared against the original word. Directed words with opposite bits at the ends and the alternating example word put the phase flip and the table switch exactly on bit boundaries. One instance per mode shares the stimulus, so both table variants are checked on the same stream.

// File: rtl/key_mod_pkg.sv
package key_mod_pkg;

  typedef enum logic {
    MODE_PHASE = 1'b0,
    MODE_FREQ  = 1'b1
  } keyMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture the parallel word
    logic emit;   // register a table sample
    logic shift;  // advance to the next bit
  } keyStrobe_t;

  // Integer sine approximation in degrees, amplitude 2^ampLog2.
  function automatic longint sineDeg(input int deg, input int ampLog2);
    int d;
    longint x;
    longint p;
    longint mag;
    d = deg % 360;
    if (d < 0) d = d + 360;
    x = (d < 180) ? longint'(d) : longint'(d - 180);
    p = x * (180 - x);
    mag = ((longint'(1) <<< ampLog2) * 4 * p) / (40500 - p);
    return (d < 180) ? mag : -mag;
  endfunction

  function automatic longint cosineDeg(input int deg, input int ampLog2);
    return sineDeg(deg + 90, ampLog2);
  endfunction

endpackage

// File: rtl/key_mod_ctrl.sv
module key_mod_ctrl #(
  parameter int WORD_W    = 14,
  parameter int TABLE_LEN = 40,
  parameter int HOLD_CYC  = 2,
  localparam int ADDR_W   = $clog2(TABLE_LEN),
  localparam int HOLD_W   = $clog2(HOLD_CYC + 1),
  localparam int BIT_W    = $clog2(WORD_W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     busy,
  output logic [ADDR_W-1:0]        addr,
  output key_mod_pkg::keyStrobe_t  strobes
);

  logic [HOLD_W-1:0] holdCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic lastHold;
  logic lastAddr;
  logic lastBit;

  assign lastHold = (holdCnt == HOLD_W'(HOLD_CYC - 1));
  assign lastAddr = (addr == ADDR_W'(TABLE_LEN - 1));
  assign lastBit  = (bitCnt == BIT_W'(WORD_W - 1));

  always_comb begin
    strobes.load  = start && !busy;
    strobes.emit  = busy;
    strobes.shift = busy && lastHold && lastAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      addr    <= '0;
      holdCnt <= '0;
      bitCnt  <= '0;
    end else if (strobes.load) begin
      busy    <= 1'b1;
      addr    <= '0;
      holdCnt <= '0;
      bitCnt  <= '0;
    end else if (busy) begin
      if (lastHold) begin
        holdCnt <= '0;
        if (lastAddr) begin
          addr <= '0;
          if (lastBit) begin
            busy <= 1'b0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end else begin
          addr <= addr + 1'b1;
        end
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/key_mod_dp.sv
module key_mod_dp #(
  parameter int WORD_W      = 14,
  parameter int TABLE_LEN   = 40,
  parameter int SAMPLE_W    = 32,
  parameter int AMP_LOG2    = 30,
  parameter int FAST_RATIO  = 20,
  parameter key_mod_pkg::keyMode_e MODE = key_mod_pkg::MODE_PHASE,
  localparam int ADDR_W     = $clog2(TABLE_LEN)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WORD_W-1:0]           dataIn,
  input  key_mod_pkg::keyStrobe_t     strobes,
  input  logic [ADDR_W-1:0]           addr,
  output logic signed [SAMPLE_W-1:0]  sampleOut,
  output logic                        sampleValid,
  output logic                        curBit
);

  logic signed [SAMPLE_W-1:0] tabOne  [TABLE_LEN];
  logic signed [SAMPLE_W-1:0] tabZero [TABLE_LEN];
  logic [WORD_W-1:0]          shiftReg;
  logic                       headBit;

  // Constant tables; the mode picks which carrier pair is built.
  if (MODE == key_mod_pkg::MODE_FREQ) begin : g_freq
    for (genvar k = 0; k < TABLE_LEN; k++) begin : g_ent
      localparam longint ONE_V  =
        key_mod_pkg::cosineDeg(k * FAST_RATIO * 360 / TABLE_LEN, AMP_LOG2);
      localparam longint ZERO_V =
        key_mod_pkg::sineDeg(k * 360 / TABLE_LEN, AMP_LOG2);
      assign tabOne[k]  = SAMPLE_W'(ONE_V);
      assign tabZero[k] = SAMPLE_W'(ZERO_V);
    end
  end else begin : g_phase
    for (genvar k = 0; k < TABLE_LEN; k++) begin : g_ent
      localparam longint BASE_V =
        key_mod_pkg::sineDeg(k * 360 / TABLE_LEN, AMP_LOG2);
      assign tabOne[k]  = SAMPLE_W'(BASE_V);
      assign tabZero[k] = SAMPLE_W'(-BASE_V);
    end
  end

  assign headBit = shiftReg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg    <= '0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
      curBit      <= 1'b0;
    end else begin
      if (strobes.load) begin
        shiftReg <= dataIn;
      end else if (strobes.shift) begin
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
      end
      if (strobes.emit) begin
        sampleOut   <= headBit ? tabOne[addr] : tabZero[addr];
        sampleValid <= 1'b1;
        curBit      <= headBit;
      end else begin
        sampleOut   <= '0;
        sampleValid <= 1'b0;
        curBit      <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/key_table_mod.sv
module key_table_mod #(
  parameter int WORD_W     = 14,
  parameter int TABLE_LEN  = 40,
  parameter int HOLD_CYC   = 2,
  parameter int SAMPLE_W   = 32,
  parameter int AMP_LOG2   = 30,
  parameter int FAST_RATIO = 20,
  parameter key_mod_pkg::keyMode_e MODE = key_mod_pkg::MODE_PHASE
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [WORD_W-1:0]           dataIn,
  output logic signed [SAMPLE_W-1:0]  sampleOut,
  output logic                        sampleValid,
  output logic                        curBit,
  output logic                        busy
);

  localparam int ADDR_W = $clog2(TABLE_LEN);

  key_mod_pkg::keyStrobe_t strobes;
  logic [ADDR_W-1:0]       addr;

  key_mod_ctrl #(
    .WORD_W(WORD_W), .TABLE_LEN(TABLE_LEN), .HOLD_CYC(HOLD_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .addr(addr), .strobes(strobes)
  );

  key_mod_dp #(
    .WORD_W(WORD_W), .TABLE_LEN(TABLE_LEN), .SAMPLE_W(SAMPLE_W),
    .AMP_LOG2(AMP_LOG2), .FAST_RATIO(FAST_RATIO), .MODE(MODE)
  ) u_dp (
    .clk(clk), .rst(rst), .dataIn(dataIn), .strobes(strobes), .addr(addr),
    .sampleOut(sampleOut), .sampleValid(sampleValid), .curBit(curBit)
  );

endmodule

// File: rtl/key_mod_chk.sv
module key_mod_chk #(
  parameter int WORD_W    = 14,
  parameter int TABLE_LEN = 40,
  parameter int HOLD_CYC  = 2,
  parameter int SAMPLE_W  = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                busy,
  input logic [SAMPLE_W-1:0] sampleOut,
  input logic                sampleValid,
  input logic                curBit
);

  localparam int SPAN = WORD_W * TABLE_LEN * HOLD_CYC;
  localparam int BIT_CYC = TABLE_LEN * HOLD_CYC;

  int validCnt;
  int busyCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      validCnt <= 0;
      busyCnt  <= 0;
    end else begin
      validCnt <= sampleValid ? validCnt + 1 : 0;
      if (start && !busy) busyCnt <= 0;
      else if (busy)      busyCnt <= busyCnt + 1;
    end
  end

  // R2: busy lasts exactly one word length
  p_busy_span_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busyCnt == SPAN);

  // R3: valid trails busy by one cycle
  p_valid_lag_r3: assert property (@(posedge clk) disable iff (rst)
    sampleValid == $past(busy));

  // R3: a sample is held for its whole hold window
  p_hold_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && (validCnt % HOLD_CYC != 0)) |-> $stable(sampleOut));

  // R4: the bit only changes on a bit boundary
  p_bit_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && (validCnt % BIT_CYC != 0)) |-> $stable(curBit));

  // R9: idle output is zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |-> (sampleOut == '0 && !curBit));

endmodule

bind key_table_mod key_mod_chk #(
  .WORD_W(WORD_W), .TABLE_LEN(TABLE_LEN), .HOLD_CYC(HOLD_CYC), .SAMPLE_W(SAMPLE_W)
) u_keyChk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .sampleOut(sampleOut), .sampleValid(sampleValid), .curBit(curBit)
);

// File: tb/key_table_mod_bench.sv
module key_table_mod_bench;

  localparam int W = 14;
  localparam int L = 40;
  localparam int H = 2;
  localparam int AMP = 30;
  localparam int RATIO = 20;
  localparam int SPAN = W * L * H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic signed [31:0] outP, outF;
  logic validP, validF, bitP, bitF, busyP, busyF;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  key_table_mod #(.MODE(key_mod_pkg::MODE_PHASE)) u_key_table_mod (
    .clk(clk), .rst(rst), .start(start), .dataIn(dataIn),
    .sampleOut(outP), .sampleValid(validP), .curBit(bitP), .busy(busyP)
  );

  key_table_mod #(.MODE(key_mod_pkg::MODE_FREQ)) u_key_table_mod_freq (
    .clk(clk), .rst(rst), .start(start), .dataIn(dataIn),
    .sampleOut(outF), .sampleValid(validF), .curBit(bitF), .busy(busyF)
  );

  function automatic longint refSine(input int deg);
    int a;
    longint y, p, mag;
    a = ((deg % 360) + 360) % 360;
    y = (a >= 180) ? longint'(a - 180) : longint'(a);
    p = y * (180 - y);
    mag = ((longint'(1) <<< AMP) * 4 * p) / (40500 - p);
    return (a >= 180) ? -mag : mag;
  endfunction

  function automatic longint refSample(input bit freqMode, input bit b, input int k);
    int step;
    step = 360 / L;
    if (freqMode) return b ? refSine(k * step * RATIO + 90) : refSine(k * step);
    return b ? refSine(k * step) : -refSine(k * step);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(!busyP && !busyF, req, "busy", busyP, 0);
    check(!validP && !validF, req, "valid", validP, 0);
    check(outP == 0 && outF == 0, req, "sample", outP, 0);
    check(!bitP && !bitF, req, "curBit", bitP, 0);
  endtask

  task automatic runWord(input logic [W-1:0] w, input int intrudeAt,
                         input logic [W-1:0] other);
    string req;
    @(negedge clk);
    start = 1'b1;
    dataIn = w;
    @(negedge clk);
    start = 1'b0;
    dataIn = ~w;
    check(busyP && busyF, "R2", "busy after start", busyP, 1);
    check(!validP, "R3", "valid lag", validP, 0);
    for (int c = 1; c <= SPAN; c++) begin
      if (c == intrudeAt) begin
        start = 1'b1;
        dataIn = other;
      end
      @(negedge clk);
      start = 1'b0;
      begin
        int idx, b, k;
        bit wb;
        idx = c - 1;
        b = idx / (L * H);
        k = (idx % (L * H)) / H;
        wb = w[W-1-b];
        req = (intrudeAt > 0) ? "R8" : "R6";
        check(validP && validF, "R3", "valid", validP, 1);
        check(outP == refSample(1'b0, wb, k), {req, " R5 phase"}, "sample",
              outP, refSample(1'b0, wb, k));
        check(outF == refSample(1'b1, wb, k), "R7 R5 freq", "sample",
              outF, refSample(1'b1, wb, k));
        check(bitP == wb && bitF == wb, "R4", "curBit", bitP, wb);
        check(busyP == (c < SPAN), "R2", "busy", busyP, (c < SPAN));
      end
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkIdle("R9");
    end
  endtask

  initial begin
    #(150000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R1");

    runWord(14'b00100101011010, 0, '0);
    runWord(14'h3FFF, 0, '0);
    runWord(14'h0000, 0, '0);
    runWord(14'b10000000000001, 0, '0);
    runWord(14'b01111111111110, 80, 14'h2AAA);   // R8 on a bit boundary
    runWord(14'h1555, SPAN, 14'h3FFF);           // R8 on the last cycle
    for (int r = 0; r < 5; r++) begin
      logic [W-1:0] w;
      logic [W-1:0] o;
      int at;
      w = W'($urandom);
      o = ~w;
      at = 1 + int'($urandom % SPAN);
      runWord(w, at, o);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule